// File: doc/BRIEF.md
# Serial Debug Scan Access Controller

This block lets a host reach the hidden registers of a processor unit over a single-bit serial path. The host raises a freeze level and then a select level. It then issues shift accesses that each move exactly one bit into a scan register. The command, a register index and, for writes, a data word go in this way. An execute strobe then makes the unit act on the command held in the scan register. After a read, the host takes the result out one bit per shift access on the scan-out pin. The host finishes by dropping select and then freeze.

Each shift is carried out internally as two sub-steps on successive clock cycles. In the first, strobe A captures the incoming bit. In the second, strobe B moves the captured bit into the scan register. A guard enforces the access order. Any shift or execute that arrives outside the permitted window is discarded, and a sticky protocol-error flag is raised. The 16-entry register file of the unit is modelled inside the block so that register transfers can be observed.

Top module: `dbg_scan_ctrl`

## Requirements
- R1: After reset, `scan_out_o`, `busy_o` and `proto_err_o` are 0, and every modelled register holds 0.
- R2: An accepted shift access raises `busy_o` for exactly the cycle after the strobe. The scan register moves one place toward bit 0 on the following edge. The captured `scan_in_i` bit enters at the top position, and `scan_out_o` always shows bit 0.
- R3: The 38-bit scan word is shifted in least significant bit first. Bits [1:0] hold the command, bits [5:2] hold the register index and bits [37:6] hold the data. After 38 shifts the first bit shifted in sits at bit 0.
- R4: Execute with command 2'b10 (write) copies bits [37:6] of the scan register into the register chosen by bits [5:2].
- R5: Execute with command 2'b01 (read) loads the chosen register into the low 32 bits of the scan register and clears the upper bits. `scan_out_o` shows data bit 0 in the cycle after the strobe, and each later shift shows the next bit.
- R6: A shift or execute strobe seen while freeze or select is low is ignored, and `proto_err_o` is set.
- R7: An execute seen while `halted_i` is low is ignored and sets `proto_err_o`.
- R8: Select rising while freeze is low, or freeze falling while select is high, sets `proto_err_o`.
- R9: `proto_err_o`, once set, stays set until reset.
- R10: A shift strobe while `busy_o` is high, or a shift strobe and an execute strobe in the same cycle, is ignored and sets `proto_err_o`.
- R11: Execute with command 2'b00 or 2'b11 changes neither the scan register nor any modelled register, and it raises no error.
- R12: Shift accesses are accepted whether `halted_i` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Host freeze level |
| select_i | input | 1 | Host select level for this unit |
| halted_i | input | 1 | High while the processor is stopped |
| shift_stb_i | input | 1 | One-cycle shift access strobe |
| exec_stb_i | input | 1 | One-cycle execute strobe |
| scan_in_i | input | 1 | Bit to shift in, taken from the host info register |
| scan_out_o | output | 1 | Bit 0 of the scan register, read through host status |
| busy_o | output | 1 | Second sub-step of a shift is in progress |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that strobes are single-cycle pulses and that `halted_i`, `freeze_i` and `select_i` change only between host accesses. The stimulus drives all inputs half a cycle away from the sampling edge. It leaves at least one idle cycle after every shift strobe, except in the test that deliberately hits the busy cycle. Every illegal sequence is aimed at a freshly reset block, so the sticky flag from one violation does not hide the next.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

    localparam int NREG_DEF   = 16;
    localparam int DATA_W_DEF = 32;
    localparam int CMD_W      = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_SPARE = 2'b11
    } scan_cmd_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } xfer_t;

    function automatic xfer_t decode_cmd(input logic [CMD_W-1:0] c);
        xfer_t x;
        x.rd = (c == CMD_READ);
        x.wr = (c == CMD_WRITE);
        return x;
    endfunction

endpackage

// File: rtl/dbg_seq_guard.sv
module dbg_seq_guard (
    input  logic clk,
    input  logic rst,
    input  logic freeze_i,
    input  logic select_i,
    input  logic halted_i,
    input  logic shift_stb_i,
    input  logic exec_stb_i,
    input  logic busy_i,
    output logic shift_ok_o,
    output logic exec_ok_o,
    output logic err_o
);
    logic frz_q, sel_q, err_q;
    logic window, order_bad, strobe_bad;

    assign window     = freeze_i && select_i;
    assign shift_ok_o = shift_stb_i && window && !busy_i && !exec_stb_i;
    assign exec_ok_o  = exec_stb_i && window && halted_i && !busy_i && !shift_stb_i;

    always_comb begin
        order_bad  = (select_i && !sel_q && !freeze_i) ||
                     (frz_q && !freeze_i && select_i);
        strobe_bad = (shift_stb_i && !shift_ok_o) || (exec_stb_i && !exec_ok_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_q <= 1'b0;
            sel_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            frz_q <= freeze_i;
            sel_q <= select_i;
            if (order_bad || strobe_bad)
                err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    p_no_window_r6: assert property (@(posedge clk) disable iff (rst)
        ((shift_stb_i || exec_stb_i) && !window) |=> err_q);
    p_running_exec_r7: assert property (@(posedge clk) disable iff (rst)
        (exec_stb_i && !halted_i) |=> err_q);
    p_busy_shift_r10: assert property (@(posedge clk) disable iff (rst)
        (shift_stb_i && busy_i) |=> err_q);
endmodule

// File: rtl/dbg_shift_path.sv
module dbg_shift_path #(
    parameter int SR_W   = 38,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_ok_i,
    input  logic              bit_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic [SR_W-1:0]   sr_o,
    output logic              busy_o
);
    localparam int PAD_W = SR_W - DATA_W;

    logic [SR_W-1:0] sr_q;
    logic            hold_q;   // sub-step A capture
    logic            pend_q;   // sub-step B pending

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            hold_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= shift_ok_i;
            if (shift_ok_i)
                hold_q <= bit_i;
            if (pend_q)
                sr_q <= {hold_q, sr_q[SR_W-1:1]};
            else if (load_i)
                sr_q <= {{PAD_W{1'b0}}, load_data_i};
        end
    end

    assign sr_o   = sr_q;
    assign busy_o = pend_q;

    p_shift_busy_r2: assert property (@(posedge clk) disable iff (rst)
        shift_ok_i |=> busy_o);
    p_busy_single_r2: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);
    p_sr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_i) |=> $stable(sr_q));
    p_load_bit0_r5: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> (sr_q[0] == $past(load_data_i[0])));
endmodule

// File: rtl/dbg_reg_model.sv
module dbg_reg_model
    import dbg_scan_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int SR_W   = 38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_ok_i,
    input  logic [SR_W-1:0]   sr_i,
    output logic              load_o,
    output logic [DATA_W-1:0] load_data_o
);
    localparam int ADDR_LO = CMD_W;
    localparam int DATA_LO = CMD_W + ADDR_W;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] wdata;
    xfer_t             op;
    logic              wr_en;

    always_comb begin
        cmd   = sr_i[CMD_W-1:0];
        idx   = sr_i[DATA_LO-1:ADDR_LO];
        wdata = sr_i[SR_W-1:DATA_LO];
        op    = decode_cmd(cmd);
        wr_en = exec_ok_i && op.wr;
    end

    assign load_o      = exec_ok_i && op.rd;
    assign load_data_o = regs_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[idx] <= wdata;
        end
    end

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs_q[$past(idx)] == $past(wdata)));
    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(load_o && wr_en));
endmodule

// File: rtl/dbg_scan_ctrl.sv
module dbg_scan_ctrl
    import dbg_scan_pkg::*;
#(
    parameter int NREG   = NREG_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic freeze_i,
    input  logic select_i,
    input  logic halted_i,
    input  logic shift_stb_i,
    input  logic exec_stb_i,
    input  logic scan_in_i,
    output logic scan_out_o,
    output logic busy_o,
    output logic proto_err_o
);
    localparam int ADDR_W = $clog2(NREG);
    localparam int SR_W   = CMD_W + ADDR_W + DATA_W;

    logic              shift_ok, exec_ok, busy, load;
    logic [SR_W-1:0]   sr;
    logic [DATA_W-1:0] load_data;

    dbg_seq_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .freeze_i    (freeze_i),
        .select_i    (select_i),
        .halted_i    (halted_i),
        .shift_stb_i (shift_stb_i),
        .exec_stb_i  (exec_stb_i),
        .busy_i      (busy),
        .shift_ok_o  (shift_ok),
        .exec_ok_o   (exec_ok),
        .err_o       (proto_err_o)
    );

    dbg_shift_path #(.SR_W(SR_W), .DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .shift_ok_i  (shift_ok),
        .bit_i       (scan_in_i),
        .load_i      (load),
        .load_data_i (load_data),
        .sr_o        (sr),
        .busy_o      (busy)
    );

    dbg_reg_model #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SR_W(SR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .exec_ok_i   (exec_ok),
        .sr_i        (sr),
        .load_o      (load),
        .load_data_o (load_data)
    );

    assign scan_out_o = sr[0];
    assign busy_o     = busy;

    p_exec_needs_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (exec_stb_i && shift_stb_i) |=> proto_err_o);
    p_run_shift_ok_r12: assert property (@(posedge clk) disable iff (rst)
        (shift_stb_i && freeze_i && select_i && !busy && !exec_stb_i && !halted_i) |=> busy_o);
endmodule

// File: tb/dbg_scan_ctrl_bench.sv
module dbg_scan_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic freeze = 1'b0, select = 1'b0, halted = 1'b1;
    logic shift_stb = 1'b0, exec_stb = 1'b0, din = 1'b0;
    logic dout, busy, err;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        int    sig;      // 0 dout, 1 err, 2 busy
        logic  val;
        string req;
    } exp_t;
    exp_t exp_q[$];
    event chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_scan_ctrl u_dbg_scan_ctrl (
        .clk(clk), .rst(rst), .freeze_i(freeze), .select_i(select),
        .halted_i(halted), .shift_stb_i(shift_stb), .exec_stb_i(exec_stb),
        .scan_in_i(din), .scan_out_o(dout), .busy_o(busy), .proto_err_o(err)
    );

    // monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic act;
                e = exp_q.pop_front();
                act = (e.sig == 0) ? dout : (e.sig == 1) ? err : busy;
                n_run++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s sig=%0d actual=%b expected=%b", e.req, e.sig, act, e.val);
                end
            end
        end
    end

    task automatic expect_sig(input int sig, input logic v, input string req);
        exp_t e;
        e.sig = sig; e.val = v; e.req = req;
        exp_q.push_back(e);
        -> chk_ev;
        #0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; freeze = 1'b0; select = 1'b0; halted = 1'b1;
        shift_stb = 1'b0; exec_stb = 1'b0; din = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_window();
        @(negedge clk); freeze = 1'b1;
        @(negedge clk); select = 1'b1;
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); din = b; shift_stb = 1'b1;
        @(negedge clk); shift_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic execute();
        @(negedge clk); exec_stb = 1'b1;
        @(negedge clk); exec_stb = 1'b0;
    endtask

    task automatic scan_in(input logic [1:0] cmd, input logic [3:0] idx, input logic [31:0] data);
        logic [37:0] w;
        w = {data, idx, cmd};
        for (int i = 0; i < 38; i++) shift_bit(w[i]);
    endtask

    task automatic read_check(input logic [3:0] idx, input logic [31:0] exp_d, input string req);
        scan_in(2'b01, idx, 32'h0);
        execute();
        expect_sig(0, exp_d[0], req);
        for (int i = 1; i < 32; i++) begin
            shift_bit(1'b0);
            expect_sig(0, exp_d[i], req);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_sig(0, 1'b0, "R1");
        expect_sig(1, 1'b0, "R1");
        expect_sig(2, 1'b0, "R1");

        open_window();
        // R2 busy timing of a single shift
        @(negedge clk); din = 1'b1; shift_stb = 1'b1;
        @(negedge clk); shift_stb = 1'b0;
        expect_sig(2, 1'b1, "R2");
        @(negedge clk);
        expect_sig(2, 1'b0, "R2");

        // R4 writes, R3 field order
        scan_in(2'b10, 4'd5, 32'hA5C3_0F1E);
        execute();
        scan_in(2'b10, 4'd12, 32'hDEAD_BEEF);
        execute();
        scan_in(2'b10, 4'd15, 32'h8000_0001);
        execute();
        expect_sig(1, 1'b0, "R4");

        // R5 read back, R1 untouched register is zero
        read_check(4'd5, 32'hA5C3_0F1E, "R5");
        read_check(4'd12, 32'hDEAD_BEEF, "R5");
        read_check(4'd15, 32'h8000_0001, "R3");
        read_check(4'd0, 32'h0, "R1");

        // R3: after 38 shifts the first bit sits at bit 0
        shift_bit(1'b1);
        for (int i = 0; i < 37; i++) shift_bit(1'b0);
        expect_sig(0, 1'b1, "R3");

        // R11: idle and spare commands do nothing
        scan_in(2'b11, 4'd7, 32'h1234_5678);
        execute();
        expect_sig(0, 1'b1, "R11");
        scan_in(2'b00, 4'd7, 32'h1234_5678);
        execute();
        expect_sig(0, 1'b0, "R11");
        expect_sig(1, 1'b0, "R11");
        read_check(4'd7, 32'h0, "R11");

        // R6: shift with select low is ignored, error set; R9 sticky
        do_reset();
        open_window();
        shift_bit(1'b1);           // sr = 1 at top
        @(negedge clk); select = 1'b0;
        @(negedge clk);
        shift_bit(1'b0);           // rejected
        expect_sig(1, 1'b1, "R6");
        @(negedge clk); select = 1'b1;
        for (int i = 0; i < 36; i++) shift_bit(1'b0);
        expect_sig(0, 1'b0, "R6"); // 37 accepted: bit at index 1
        shift_bit(1'b0);
        expect_sig(0, 1'b1, "R6"); // 38 accepted: bit at index 0
        repeat (5) @(negedge clk);
        expect_sig(1, 1'b1, "R9");

        // R6: execute with freeze low
        do_reset();
        @(negedge clk); exec_stb = 1'b1;
        @(negedge clk); exec_stb = 1'b0;
        expect_sig(1, 1'b1, "R6");

        // R7 running execute ignored; R12 shifts while running
        do_reset();
        open_window();
        halted = 1'b0;
        scan_in(2'b10, 4'd3, 32'hCAFE_F00D);
        expect_sig(1, 1'b0, "R12");
        expect_sig(0, 1'b0, "R12");  // cmd bit0 of 2'b10
        execute();
        expect_sig(1, 1'b1, "R7");
        halted = 1'b1;
        read_check(4'd3, 32'h0, "R7");

        // R8 order violations
        do_reset();
        @(negedge clk); select = 1'b1;
        @(negedge clk);
        expect_sig(1, 1'b1, "R8");
        do_reset();
        open_window();
        expect_sig(1, 1'b0, "R8");
        @(negedge clk); freeze = 1'b0;
        @(negedge clk);
        expect_sig(1, 1'b1, "R8");

        // R10 both strobes at once
        do_reset();
        open_window();
        @(negedge clk); shift_stb = 1'b1; exec_stb = 1'b1; din = 1'b1;
        @(negedge clk); shift_stb = 1'b0; exec_stb = 1'b0;
        expect_sig(2, 1'b0, "R10");
        expect_sig(1, 1'b1, "R10");

        // R10 shift strobe during busy cycle
        do_reset();
        open_window();
        @(negedge clk); din = 1'b1; shift_stb = 1'b1;
        @(negedge clk); din = 1'b0;          // still strobing: busy cycle
        @(negedge clk); shift_stb = 1'b0;
        @(negedge clk);
        expect_sig(1, 1'b1, "R10");
        for (int i = 0; i < 37; i++) shift_bit(1'b0);
        expect_sig(0, 1'b1, "R10");

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule